// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block behaves as a byte-wide serial EEPROM on a two-wire bus, and the whole interface runs from one fast system clock. The bus clock and data lines are sampled as ordinary inputs. The block never drives the data line high. Instead it raises `sda_pull`, and the line is pulled low outside the block. The master addresses the target through a device-select byte, and two strap inputs take part in that match. A two-byte word address follows. After that come data bytes to write or bytes read back from the array.

Written bytes go into a page buffer and do not reach the array at once. The stop condition that closes the write starts a self-timed write cycle. During that cycle the buffered bytes are copied into the array, and the target ignores its own device-select byte. A write-protect input blocks every update.

The array holds `2**ADDR_W` bytes. A product build uses `ADDR_W` 14 or 15. The default of 9 keeps the model small.

Top module: `i2cee_target`

## Requirements
- R1: After reset `sda_pull` is low, no write cycle is running, and the first correctly addressed device-select byte is acknowledged.
- R2: A falling data line while the bus clock is high is a start condition, and a rising one is a stop condition. A start condition that arrives partway through any byte abandons the transfer, and the target then receives a fresh device-select byte.
- R3: The device-select byte is `1010`, then `0`, then strap A1, then strap A0, then the direction bit (1 = read). Any other value is not acknowledged, and the target stays silent until the next start condition.
- R4: Bytes travel most significant bit first. Bits are sampled on the rising bus clock. The target changes `sda_pull` only after a falling bus clock, and it holds the line low for the ninth clock of every byte it acknowledges.
- R5: The word address arrives high byte first. High-byte bits above `ADDR_W-8` are ignored.
- R6: A write sequence takes 1 to 64 data bytes. The low 6 address bits advance after each byte and wrap within the 64-byte page. The upper bits stay fixed.
- R7: A stop condition that ends a write holding at least one accepted byte starts a write cycle of `BUSY_CLKS` clocks. The array changes only within that cycle. The device-select byte is not acknowledged while the cycle runs.
- R8: While `wp` is high, data bytes are not acknowledged, nothing is buffered, and the stop condition starts no write cycle.
- R9: A read returns the byte at the current address, and the address then advances by one, wrapping at the end of the array. A read can be current-address, random (address write, then a repeated start) or sequential. It continues while the master acknowledges and ends at a master NACK.
- R10: A start condition, including a repeated start, discards any data bytes that were accepted but not yet committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl | input | 1 | Bus clock level |
| sda_in | input | 1 | Data line level as seen on the bus |
| sda_pull | output | 1 | Pull the data line low when high |
| strap_a1 | input | 1 | Address strap, upper bit |
| strap_a0 | input | 1 | Address strap, lower bit |
| wp | input | 1 | Write protect, high blocks all writes |

## Verification
Two events can fall in the same stretch of time: the running write cycle and a new bus transaction. The bench provokes this by sending a device-select byte straight after the stop that ends a page write. It expects a NACK, because the array commit is still under way. After `BUSY_CLKS` have passed, it expects an ACK. A second case puts a write-protected stop in the same position and expects an immediate ACK, since no write cycle was started.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_ACK,
        ST_RDAT,
        ST_RACK
    } bus_st_e;

    localparam logic [3:0] DEV_FAMILY = 4'b1010;
    localparam int         PAGE_W     = 6;

endpackage

// File: rtl/i2cee_line_watch.sv
module i2cee_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl_q;
        logic sda_q;
        logic scl_p;
        logic sda_p;
    } line_t;

    line_t d, q;

    always_comb begin
        d       = q;
        d.scl_q = scl_in;
        d.sda_q = sda_in;
        d.scl_p = q.scl_q;
        d.sda_p = q.sda_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_lvl   = q.sda_q;
    assign scl_rise  = q.scl_q & ~q.scl_p;
    assign scl_fall  = ~q.scl_q & q.scl_p;
    assign start_det = q.scl_q & q.scl_p & q.sda_p & ~q.sda_q;
    assign stop_det  = q.scl_q & q.scl_p & ~q.sda_p & q.sda_q;

endmodule

// File: rtl/i2cee_array.sv
module i2cee_array #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/i2cee_page_commit.sv
// Page buffer plus self-timed write cycle. BUSY_CLKS must be at least
// the page size so the scan finishes inside the cycle.
module i2cee_page_commit #(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 6,
    parameter int BUSY_CLKS = 300
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_data,
    input  logic                     discard,
    input  logic                     go,
    input  logic [ADDR_W-PAGE_W-1:0] go_page,
    output logic                     busy,
    output logic                     any_pending,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [7:0]               mem_data
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int TMR_W      = $clog2(BUSY_CLKS + 1);
    localparam int SCAN_W     = PAGE_W + 1;
    localparam int PG_W       = ADDR_W - PAGE_W;

    typedef struct packed {
        logic [TMR_W-1:0]      tmr;
        logic [SCAN_W-1:0]     scan;
        logic [PG_W-1:0]       page;
        logic [PAGE_BYTES-1:0] valid;
    } cm_t;

    cm_t d, q;
    logic [7:0] bytes_q [PAGE_BYTES];

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        if (q.tmr != '0) begin
            d.tmr = q.tmr - 1'b1;
            if (!q.scan[PAGE_W]) begin
                mem_we = q.valid[q.scan[PAGE_W-1:0]];
                d.scan = q.scan + 1'b1;
            end
            if (q.tmr == TMR_W'(1)) d.valid = '0;
        end else if (go) begin
            d.tmr  = TMR_W'(BUSY_CLKS);
            d.scan = '0;
            d.page = go_page;
        end else begin
            if (discard) d.valid = '0;
            if (buf_we)  d.valid[buf_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (buf_we && q.tmr == '0) bytes_q[buf_idx] <= buf_data;
    end

    assign busy        = (q.tmr != '0);
    assign any_pending = |q.valid;
    assign mem_addr    = {q.page, q.scan[PAGE_W-1:0]};
    assign mem_data    = bytes_q[q.scan[PAGE_W-1:0]];

endmodule

// File: rtl/i2cee_target.sv
module i2cee_target
    import i2cee_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int BUSY_CLKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda_in,
    output logic sda_pull,
    input  logic strap_a1,
    input  logic strap_a0,
    input  logic wp
);
    localparam int HI_W = ADDR_W - 8;
    localparam int PG_W = ADDR_W - PAGE_W;

    typedef struct packed {
        bus_st_e           st;
        bus_st_e           after;
        logic [3:0]        bitcnt;
        logic [7:0]        shreg;
        logic              pull;
        logic              mack;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t d, q;

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic busy, any_pending, mem_we, buf_we, go, ack_ok, dev_match;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_data, rdata;

    i2cee_line_watch u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl),
        .sda_in   (sda_in),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2cee_page_commit #(
        .ADDR_W   (ADDR_W),
        .PAGE_W   (PAGE_W),
        .BUSY_CLKS(BUSY_CLKS)
    ) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_we     (buf_we),
        .buf_idx    (q.addr[PAGE_W-1:0]),
        .buf_data   (q.shreg),
        .discard    (start_det),
        .go         (go),
        .go_page    (q.addr[ADDR_W-1:PAGE_W]),
        .busy       (busy),
        .any_pending(any_pending),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data)
    );

    i2cee_array #(.ADDR_W(ADDR_W)) u_array (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_addr),
        .wdata(mem_data),
        .raddr(q.addr),
        .rdata(rdata)
    );

    assign dev_match = (q.shreg[7:1] == {DEV_FAMILY, 1'b0, strap_a1, strap_a0});

    always_comb begin
        d      = q;
        buf_we = 1'b0;
        go     = 1'b0;
        ack_ok = 1'b0;
        if (start_det) begin
            d.st     = ST_DEV;
            d.bitcnt = '0;
            d.pull   = 1'b0;
        end else if (stop_det) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
            go     = any_pending && !wp && !busy;
        end else begin
            case (q.st)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.shreg  = {q.shreg[6:0], sda_lvl};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.bitcnt = '0;
                        case (q.st)
                            ST_DEV: begin
                                ack_ok  = dev_match && !busy;
                                d.after = q.shreg[0] ? ST_RDAT : ST_AHI;
                            end
                            ST_AHI: begin
                                ack_ok = 1'b1;
                                d.addr[ADDR_W-1:8] = q.shreg[HI_W-1:0];
                                d.after = ST_ALO;
                            end
                            ST_ALO: begin
                                ack_ok = 1'b1;
                                d.addr[7:0] = q.shreg;
                                d.after = ST_WDAT;
                            end
                            default: begin
                                ack_ok  = !wp;
                                buf_we  = !wp;
                                d.after = ST_WDAT;
                                if (!wp) d.addr[PAGE_W-1:0] = q.addr[PAGE_W-1:0] + 1'b1;
                            end
                        endcase
                        if (ack_ok) begin
                            d.st   = ST_ACK;
                            d.pull = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.st     = q.after;
                        d.bitcnt = '0;
                        d.pull   = 1'b0;
                        if (q.after == ST_RDAT) begin
                            d.shreg = rdata;
                            d.pull  = ~rdata[7];
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.bitcnt < 4'd8) begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.pull  = ~q.shreg[6];
                        end else begin
                            d.pull   = 1'b0;
                            d.addr   = q.addr + 1'b1;
                            d.st     = ST_RACK;
                            d.bitcnt = '0;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st    = ST_RDAT;
                            d.shreg = rdata;
                            d.pull  = ~rdata[7];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.after  <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_pull = q.pull;

endmodule

// File: rtl/i2cee_target_chk.sv
module i2cee_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl,
    input logic sda_pull,
    input logic wp,
    input logic busy,
    input logic mem_we,
    input logic buf_we,
    input logic stop_det
);
    // R4
    pull_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl);

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull);

    // R7
    commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R7
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R6
    buf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !busy);

    // R8
    wp_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp && stop_det && !busy) |=> !busy);

endmodule

bind i2cee_target i2cee_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl     (scl),
    .sda_pull(sda_pull),
    .wp      (wp),
    .busy    (busy),
    .mem_we  (mem_we),
    .buf_we  (buf_we),
    .stop_det(stop_det)
);

// File: tb/test_i2cee_target.sv
`timescale 1ns/1ps
module test_i2cee_target;
    localparam int HP    = 4;
    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;
    localparam int BUSY  = 300;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic [1:0] strap = 2'b10;
    wire  sda_pull;
    wire  sda_bus = sda_m & ~sda_pull;

    int nchk = 0, nfail = 0;
    bit done = 0;
    int expm [DEPTH];

    i2cee_target #(.ADDR_W(AW), .BUSY_CLKS(BUSY)) i_i2cee_target (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_bus), .sda_pull(sda_pull),
        .strap_a1(strap[1]), .strap_a0(strap[0]), .wp(wp));

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; hw(HP); scl = 1; hw(HP); sda_m = 0; hw(HP); scl = 0; hw(HP);
    endtask

    task automatic bus_stop();
        sda_m = 0; hw(HP); scl = 1; hw(HP); sda_m = 1; hw(HP);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            sda_m = b[7-i]; hw(HP); scl = 1; hw(HP); scl = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1; hw(HP); scl = 1; hw(HP/2);
        acked = (sda_bus == 1'b0);
        hw(HP - HP/2); scl = 0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            hw(HP); scl = 1; hw(HP/2); b[i] = sda_bus; hw(HP - HP/2); scl = 0;
        end
        sda_m = !mack; hw(HP); scl = 1; hw(HP); scl = 0; hw(1); sda_m = 1;
    endtask

    function automatic logic [7:0] dev(input logic [3:0] fam, input logic [1:0] st, input bit rw);
        return {fam, 1'b0, st, rw};
    endfunction

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed + k * 29) ^ (k >> 2));
    endfunction

    task automatic probe(input logic [3:0] fam, input logic [1:0] st, input bit exp_ack, input string req);
        bit ak;
        bus_start(); send_byte(dev(fam, st, 1'b0), ak); bus_stop();
        chk(ak == exp_ack, req, ak, exp_ack);
    endtask

    task automatic write_txn(input int a, input int n, input int seed, input bit exp_dack, input string req);
        bit ak;
        int base;
        base = a & (DEPTH - 1);
        bus_start();
        send_byte(dev(4'b1010, strap, 1'b0), ak); chk(ak, req, ak, 1);
        send_byte(8'(a >> 8), ak);                chk(ak, req, ak, 1);
        send_byte(8'(a), ak);                     chk(ak, req, ak, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(pat(seed, k), ak);
            chk(ak == exp_dack, req, ak, exp_dack);
            if (!ak) break;
        end
        bus_stop();
        if (exp_dack)
            for (int k = 0; k < n; k++)
                expm[(base & ~63) | ((base + k) & 63)] = int'(pat(seed, k));
    endtask

    task automatic read_data(input int a, input int n, input string req);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(b == 8'(expm[(a + k) % DEPTH]), req, b, expm[(a + k) % DEPTH]);
        end
        bus_stop();
    endtask

    task automatic read_txn(input int a, input int n, input string req);
        bit ak;
        bus_start();
        send_byte(dev(4'b1010, strap, 1'b0), ak); chk(ak, req, ak, 1);
        send_byte(8'(a >> 8), ak);                chk(ak, req, ak, 1);
        send_byte(8'(a), ak);                     chk(ak, req, ak, 1);
        bus_start();
        send_byte(dev(4'b1010, strap, 1'b1), ak); chk(ak, req, ak, 1);
        read_data(a, n, req);
    endtask

    initial begin
        bit ak;
        hw(10);
        // R1: reset state
        chk(sda_pull == 1'b0, "R1", sda_pull, 0);
        rst_n = 1; hw(10);
        probe(4'b1010, strap, 1, "R1");

        // R6, R7: full-page fills, busy probe right after the first stop
        for (int p = 0; p < DEPTH / 64; p++) begin
            write_txn(p * 64, 64, p * 17 + 1, 1, "R6");
            if (p == 0) probe(4'b1010, strap, 0, "R7 busy nack");
            hw(BUSY + 20);
            if (p == 0) probe(4'b1010, strap, 1, "R7 ack after cycle");
        end

        // R9: sequential read across the whole array and wrap to 0
        read_txn(0, DEPTH + 1, "R9 seq");

        // R6: partial page with wrap inside the page
        write_txn(3 * 64 + 62, 5, 200, 1, "R6 wrap");
        hw(BUSY + 20);
        read_txn(3 * 64, 64, "R6 wrap");

        // R5: ignored high address bits, R9 wrap at array end
        write_txn(16'hFFFF, 1, 90, 1, "R5");
        hw(BUSY + 20);
        read_txn(DEPTH - 1, 2, "R5");

        // R8: write protect
        wp = 1;
        write_txn(64 + 10, 3, 55, 0, "R8");
        probe(4'b1010, strap, 1, "R8 no cycle");
        wp = 0;
        read_txn(64 + 8, 6, "R8");

        // R3: mismatched straps and family code
        probe(4'b1010, 2'b01, 0, "R3 strap");
        probe(4'b1011, strap, 0, "R3 family");
        probe(4'b1010, 2'b00, 0, "R3 strap");

        // R2: start in the middle of a device-select byte
        bus_start();
        send_bits(8'hA4, 3);
        bus_start();
        send_byte(dev(4'b1010, strap, 1'b0), ak); chk(ak, "R2 restart", ak, 1);
        bus_stop();

        // R2, R10: start in the middle of a data byte discards buffered data
        bus_start();
        send_byte(dev(4'b1010, strap, 1'b0), ak); chk(ak, "R10", ak, 1);
        send_byte(8'h00, ak);                     chk(ak, "R10", ak, 1);
        send_byte(8'd130, ak);                    chk(ak, "R10", ak, 1);
        send_byte(8'h11, ak);                     chk(ak, "R10", ak, 1);
        send_byte(8'h22, ak);                     chk(ak, "R10", ak, 1);
        send_bits(8'h33, 4);
        bus_start();
        send_byte(dev(4'b1010, strap, 1'b0), ak); chk(ak, "R2 abort", ak, 1);
        bus_stop();
        probe(4'b1010, strap, 1, "R10 no cycle");
        read_txn(128, 6, "R10");

        // R9: current-address read follows a random read
        read_txn(300, 1, "R9 random");
        bus_start();
        send_byte(dev(4'b1010, strap, 1'b1), ak); chk(ak, "R9 current", ak, 1);
        read_data(301, 3, "R9 current");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

endmodule